// File: doc/BRIEF.md
# Fusing Decode Slot Allocator

This block sits between an instruction queue and five decode lanes. Each cycle it looks at up to five queued instructions of the thread now being served. Each one comes with its micro-op count and two class tags: a compare/test tag and a conditional-jump tag. The block then decides which instructions are issued this cycle and on which lanes. Lane 0 is the complex lane and may emit one to four micro-ops. Lanes 1 to 4 are simple lanes that take only single-micro-op instructions. Every micro-op beyond the first on lane 0 takes one simple lane away, starting from the highest. A compare or test followed directly by a conditional jump is merged into one operation on one lane, at most once per cycle.

An instruction in slot 0 that needs more than four micro-ops is handed to a microcode sequencer stub. The sequencer then streams the micro-ops at up to four per cycle while normal decode is held off. The queue learns from `consumeCnt` how many entries to retire, and from `servThread` which thread to present. The serving thread flips after every normal decode cycle. When the downstream side drops `outRdy`, the whole block stalls.

Top module: `fuse_decode_alloc`

## Requirements
- R1: Out of reset `servThread` is 0, `seqBusy` is 0, and while no instruction is valid no lane is valid, `consumeCnt` is 0 and `uopsOut` is 0.
- R2: On a decode cycle, a valid slot-0 instruction of 1 to 4 micro-ops is placed on lane 0, and `lane0Uops` reports its count. A fused pair reports 1. The micro-op count of slot i is `inUops[4i+3:4i]`, and a value of 0 counts as 1.
- R3: Simple lanes take only instructions of exactly one micro-op, in program order, filling lanes upward from lane 1. Simple lane k is usable only if k <= 5 - lane0Uops. Issue stops at the first invalid slot, or at the first instruction after slot 0 that needs more than one micro-op; that instruction waits for lane 0 in a later cycle.
- R4: `uopsOut` is the total number of micro-ops delivered in the cycle. It is the sum over the active lanes on decode cycles and the sequencer's burst on sequencer cycles. It never exceeds 5.
- R5: When slot i has its compare tag (`inCmp[i]`), slot i+1 is valid with its jump tag (`inJcc[i+1]`), and both are one micro-op, the two go out as one operation. That operation takes one lane, sets that lane's bit in `laneFused`, and consumes two slots.
- R6: At most one fusion is formed per cycle, and it is the earliest eligible pair. A later compare that could have fused is issued alone. So is a compare whose jump is not in a valid following slot of the same cycle.
- R7: `consumeCnt` equals the number of queue slots used in the cycle. A fused pair counts as two and a sequencer handoff counts as one.
- R8: A valid slot-0 instruction of more than 4 micro-ops is handed off in that cycle: no lane is active, `consumeCnt` is 1, and `seqBusy` is high from the next cycle. While busy, each ready cycle emits min(4, remaining) micro-ops, with no lanes active and nothing consumed, until the remainder reaches zero.
- R9: `servThread` toggles after every cycle in which the decoders ran (ready, sequencer idle, no handoff). It holds across handoff, sequencer and stall cycles.
- R10: While `outRdy` is low no lane is valid, `consumeCnt` and `uopsOut` are 0, and neither the sequencer's remainder nor `servThread` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| outRdy | input | 1 | Downstream can accept micro-ops this cycle |
| inValid | input | 5 | Per-slot valid of the presented queue window |
| inUops | input | 20 | Per-slot micro-op count, 4 bits per slot |
| inCmp | input | 5 | Per-slot compare/test tag |
| inJcc | input | 5 | Per-slot conditional-jump tag |
| servThread | output | 1 | Thread whose instructions the queue must present |
| consumeCnt | output | 3 | Queue slots retired this cycle |
| laneValid | output | 5 | Active decode lanes, bit k = lane k |
| laneFused | output | 5 | Lane carries a fused compare-and-jump |
| lane0Uops | output | 3 | Micro-ops issued on the complex lane |
| seqBusy | output | 1 | Microcode sequencer owns the output |
| uopsOut | output | 3 | Total micro-ops delivered this cycle |

## Verification
On every cycle the assertions check the structural rules. The lane mask must be a contiguous run from lane 0, with at most one fused lane. Decode totals stay within five and sequencer bursts within four. No lane may be active while the sequencer holds the output. A stall must freeze the state, and the thread must flip after each decode cycle. Only the bench scenarios can show that the right instructions were chosen. That covers the cut at a multi-micro-op instruction after slot 0, the choice of the earliest fusable pair, a lone compare in the last slot, the exact burst sequence of a long instruction across stalls, and the slot count handed back to the queue.

// File: rtl/fuse_decode_pkg.sv
package fuse_decode_pkg;
  localparam int SeqCntW = 3;

  typedef struct packed {
    logic               decodeEn;
    logic [SeqCntW-1:0] seqCount;
  } dsaStrobeT;
endpackage

// File: rtl/fuse_decode_path.sv
module fuse_decode_path
  import fuse_decode_pkg::*;
#(
  parameter int NUM_LANES = 5,
  parameter int MAX_CPLX  = 4,
  parameter int UOPW      = 4,
  localparam int CW = $clog2(MAX_CPLX + 1),
  localparam int SW = $clog2(NUM_LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dsaStrobeT                 strb,
  input  logic [NUM_LANES-1:0]      inValid,
  input  logic [NUM_LANES*UOPW-1:0] inUops,
  input  logic [NUM_LANES-1:0]      inCmp,
  input  logic [NUM_LANES-1:0]      inJcc,
  output logic                      handoffReq,
  output logic [UOPW-1:0]           handoffUops,
  output logic [SW-1:0]             consumeCnt,
  output logic [NUM_LANES-1:0]      laneValid,
  output logic [NUM_LANES-1:0]      laneFused,
  output logic [CW-1:0]             lane0Uops,
  output logic [SW-1:0]             uopsOut
);
  logic [NUM_LANES:0] vld;
  logic [NUM_LANES:0] cmpTag;
  logic [NUM_LANES:0] jccTag;
  logic [UOPW-1:0]    cnt [NUM_LANES+1];

  // pad the window by one empty slot so pair lookups never leave the array
  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) begin
      vld[i]    = inValid[i];
      cmpTag[i] = inCmp[i];
      jccTag[i] = inJcc[i];
      cnt[i]    = (inUops[i*UOPW +: UOPW] == '0) ? UOPW'(1) : inUops[i*UOPW +: UOPW];
    end
    vld[NUM_LANES]    = 1'b0;
    cmpTag[NUM_LANES] = 1'b0;
    jccTag[NUM_LANES] = 1'b0;
    cnt[NUM_LANES]    = UOPW'(1);
  end

  function automatic logic pairOk(input int s, input logic [NUM_LANES:0] v,
                                  input logic [NUM_LANES:0] c, input logic [NUM_LANES:0] j,
                                  input logic [UOPW-1:0] n0, input logic [UOPW-1:0] n1);
    return v[s] && c[s] && v[s+1] && j[s+1] && (n0 == UOPW'(1)) && (n1 == UOPW'(1));
  endfunction

  always_comb begin
    int idx;
    int lim;
    int sum;
    logic fusedUsed;
    logic stop;
    handoffReq  = 1'b0;
    handoffUops = '0;
    laneValid   = '0;
    laneFused   = '0;
    lane0Uops   = '0;
    idx         = 0;
    sum         = 0;
    lim         = 0;
    fusedUsed   = 1'b0;
    stop        = 1'b0;
    if (strb.decodeEn && vld[0]) begin
      if (int'(cnt[0]) > MAX_CPLX) begin
        handoffReq  = 1'b1;
        handoffUops = cnt[0];
        idx         = 1;
      end else begin
        laneValid[0] = 1'b1;
        if (pairOk(0, vld, cmpTag, jccTag, cnt[0], cnt[1])) begin
          laneFused[0] = 1'b1;
          fusedUsed    = 1'b1;
          idx          = 2;
        end else begin
          idx = 1;
        end
        lane0Uops = CW'(cnt[0]);
        sum       = int'(cnt[0]);
        // every extra complex micro-op removes one simple lane from the top
        lim       = NUM_LANES - int'(cnt[0]);
        for (int k = 1; k < NUM_LANES; k++) begin
          if (!stop && k <= lim && idx < NUM_LANES) begin
            if (vld[idx] && cnt[idx] == UOPW'(1)) begin
              laneValid[k] = 1'b1;
              sum          = sum + 1;
              if (!fusedUsed && pairOk(idx, vld, cmpTag, jccTag, cnt[idx], cnt[idx+1])) begin
                laneFused[k] = 1'b1;
                fusedUsed    = 1'b1;
                idx          = idx + 2;
              end else begin
                idx = idx + 1;
              end
            end else begin
              stop = 1'b1;
            end
          end
        end
      end
    end
    consumeCnt = SW'(idx);
    uopsOut    = strb.decodeEn ? SW'(sum) : SW'(strb.seqCount);
  end

  AST_UOP_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    int'(uopsOut) <= NUM_LANES); // R4
  AST_ONE_FUSION: assert property (@(posedge clk) disable iff (!rstN)
    $countones(laneFused) <= 1); // R6
  AST_LANE_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    ((laneValid + 1'b1) & laneValid) == '0); // R3
  AST_FUSED_ON_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (laneFused & ~laneValid) == '0); // R5
  AST_SEQ_OWNS_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.decodeEn |-> (laneValid == '0 && consumeCnt == '0)); // R8
  AST_HANDOFF_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    handoffReq |-> (laneValid == '0 && consumeCnt == SW'(1))); // R8
endmodule

// File: rtl/fuse_decode_ctrl.sv
module fuse_decode_ctrl
  import fuse_decode_pkg::*;
#(
  parameter int UOPW     = 4,
  parameter int SEQ_RATE = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            outRdy,
  input  logic            handoffReq,
  input  logic [UOPW-1:0] handoffUops,
  output dsaStrobeT       strb,
  output logic            servThread,
  output logic            seqBusy
);
  logic [UOPW-1:0] remUops;

  assign seqBusy = (remUops != '0);

  always_comb begin
    strb.decodeEn = outRdy && !seqBusy;
    strb.seqCount = '0;
    if (outRdy && seqBusy)
      strb.seqCount = (int'(remUops) > SEQ_RATE) ? SeqCntW'(SEQ_RATE) : SeqCntW'(remUops);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remUops    <= '0;
      servThread <= 1'b0;
    end else begin
      if (strb.decodeEn && handoffReq)
        remUops <= handoffUops;
      else if (strb.seqCount != '0)
        remUops <= remUops - UOPW'(strb.seqCount);
      if (strb.decodeEn && !handoffReq)
        servThread <= !servThread;
    end
  end

  AST_SEQ_RATE: assert property (@(posedge clk) disable iff (!rstN)
    int'(strb.seqCount) <= SEQ_RATE); // R8
  AST_HANDOFF_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decodeEn && handoffReq) |=> seqBusy); // R8
  AST_THREAD_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decodeEn && !handoffReq) |=> (servThread != $past(servThread))); // R9
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !outRdy |=> ($stable(remUops) && $stable(servThread))); // R10
endmodule

// File: rtl/fuse_decode_alloc.sv
module fuse_decode_alloc
  import fuse_decode_pkg::*;
#(
  parameter int NUM_LANES = 5,
  parameter int MAX_CPLX  = 4,
  parameter int UOPW      = 4,
  parameter int SEQ_RATE  = 4,
  localparam int CW = $clog2(MAX_CPLX + 1),
  localparam int SW = $clog2(NUM_LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      outRdy,
  input  logic [NUM_LANES-1:0]      inValid,
  input  logic [NUM_LANES*UOPW-1:0] inUops,
  input  logic [NUM_LANES-1:0]      inCmp,
  input  logic [NUM_LANES-1:0]      inJcc,
  output logic                      servThread,
  output logic [SW-1:0]             consumeCnt,
  output logic [NUM_LANES-1:0]      laneValid,
  output logic [NUM_LANES-1:0]      laneFused,
  output logic [CW-1:0]             lane0Uops,
  output logic                      seqBusy,
  output logic [SW-1:0]             uopsOut
);
  dsaStrobeT       strb;
  logic            handoffReq;
  logic [UOPW-1:0] handoffUops;

  fuse_decode_ctrl #(.UOPW(UOPW), .SEQ_RATE(SEQ_RATE)) u_ctrl (
    .clk(clk), .rstN(rstN), .outRdy(outRdy),
    .handoffReq(handoffReq), .handoffUops(handoffUops),
    .strb(strb), .servThread(servThread), .seqBusy(seqBusy)
  );

  fuse_decode_path #(.NUM_LANES(NUM_LANES), .MAX_CPLX(MAX_CPLX), .UOPW(UOPW)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inValid(inValid), .inUops(inUops), .inCmp(inCmp), .inJcc(inJcc),
    .handoffReq(handoffReq), .handoffUops(handoffUops),
    .consumeCnt(consumeCnt), .laneValid(laneValid), .laneFused(laneFused),
    .lane0Uops(lane0Uops), .uopsOut(uopsOut)
  );
endmodule

// File: tb/fuse_decode_alloc_bench.sv
module fuse_decode_alloc_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        outRdy = 1'b0;
  logic [4:0]  inValid = '0;
  logic [19:0] inUops = '0;
  logic [4:0]  inCmp = '0;
  logic [4:0]  inJcc = '0;
  logic        servThread;
  logic [2:0]  consumeCnt;
  logic [4:0]  laneValid;
  logic [4:0]  laneFused;
  logic [2:0]  lane0Uops;
  logic        seqBusy;
  logic [2:0]  uopsOut;

  int checks = 0;
  int errors = 0;
  int mRem = 0;
  logic mThread = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  fuse_decode_alloc u_fuse_decode_alloc (
    .clk(clk), .rstN(rstN), .outRdy(outRdy), .inValid(inValid), .inUops(inUops),
    .inCmp(inCmp), .inJcc(inJcc), .servThread(servThread), .consumeCnt(consumeCnt),
    .laneValid(laneValid), .laneFused(laneFused), .lane0Uops(lane0Uops),
    .seqBusy(seqBusy), .uopsOut(uopsOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int cntOf(input int s);
    int v;
    if (s > 4) return 1;
    v = int'(inUops[s*4 +: 4]);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit canPair(input int s);
    if (s > 3) return 1'b0;
    return inValid[s] && inCmp[s] && inValid[s+1] && inJcc[s+1] && cntOf(s) == 1 && cntOf(s+1) == 1;
  endfunction

  // reference from the requirements; computes expectations and advances model state
  task automatic evalStep();
    int eLanes = 0, eFused = 0, eL0 = 0, eCons = 0, eOut = 0;
    int pos, lim, n;
    bit fuseDone = 1'b0;
    check("R9 servThread", int'(servThread), int'(mThread));
    check("R8 seqBusy", int'(seqBusy), (mRem != 0) ? 1 : 0);
    if (!outRdy) begin
      // R10: stall, nothing moves
    end else if (mRem != 0) begin
      n = (mRem > 4) ? 4 : mRem;
      eOut = n;
      mRem -= n;
    end else if (inValid[0] && cntOf(0) > 4) begin
      eCons = 1;
      mRem = cntOf(0);
    end else begin
      if (inValid[0]) begin
        eLanes = 1;
        eL0 = cntOf(0);
        eOut = eL0;
        if (canPair(0)) begin eFused = 1; fuseDone = 1'b1; pos = 2; end
        else pos = 1;
        lim = 5 - eL0;
        for (int k = 1; k <= lim; k++) begin
          if (pos > 4) break;
          if (!(inValid[pos] && cntOf(pos) == 1)) break;
          eLanes |= (1 << k);
          eOut++;
          if (!fuseDone && canPair(pos)) begin
            eFused |= (1 << k); fuseDone = 1'b1; pos += 2;
          end else pos += 1;
        end
        eCons = pos;
      end
      mThread = !mThread;
    end
    check("R3 laneValid", int'(laneValid), eLanes);
    check("R5 laneFused", int'(laneFused), eFused);
    check("R2 lane0Uops", int'(lane0Uops), eL0);
    check("R7 consumeCnt", int'(consumeCnt), eCons);
    check("R4 uopsOut", int'(uopsOut), eOut);
  endtask

  task automatic drive(input bit rdy, input logic [4:0] v, input logic [19:0] u,
                       input logic [4:0] c, input logic [4:0] j);
    @(negedge clk);
    outRdy = rdy; inValid = v; inUops = u; inCmp = c; inJcc = j;
    #1;
    evalStep();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] u;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;
    // R1 reset state
    check("R1 servThread", int'(servThread), 0);
    check("R1 seqBusy", int'(seqBusy), 0);
    check("R1 laneValid", int'(laneValid), 0);
    check("R1 consumeCnt", int'(consumeCnt), 0);
    check("R1 uopsOut", int'(uopsOut), 0);

    drive(1, 5'b11111, 20'h11111, '0, '0);                 // all simple
    check("R3 five lanes", int'(laneValid), 5'b11111);
    drive(1, 5'b11111, 20'h11113, '0, '0);                 // 3-uop complex
    check("R3 budget cut", int'(laneValid), 5'b00111);
    drive(1, 5'b11111, 20'h11211, '0, '0);                 // multi-uop at slot 2
    check("R3 in-order stop", int'(consumeCnt), 2);
    drive(1, 5'b11111, 20'h11111, 5'b00101, 5'b01010);     // two fusable pairs
    check("R6 single fusion", int'(laneFused), 5'b00001);
    check("R6 consume", int'(consumeCnt), 5);
    drive(1, 5'b11111, 20'h11111, 5'b10000, 5'b00000);     // compare in last slot
    check("R6 lone compare", int'(laneFused), 0);
    drive(1, 5'b00111, 20'h00111, 5'b00010, 5'b00100);     // fusion at slot 1
    check("R5 fused lane1", int'(laneFused), 5'b00010);
    drive(0, 5'b11111, 20'h11111, '0, '0);
    check("R10 stall", int'(laneValid), 0);
    drive(1, 5'b11111, 20'h1111A, '0, '0);                 // 10 uops -> handoff
    check("R8 handoff", int'(consumeCnt), 1);
    drive(1, 5'b11111, 20'h11111, '0, '0);
    check("R8 burst1", int'(uopsOut), 4);
    drive(0, 5'b11111, 20'h11111, '0, '0);
    check("R10 seq hold", int'(uopsOut), 0);
    drive(1, 5'b11111, 20'h11111, '0, '0);
    drive(1, 5'b11111, 20'h11111, '0, '0);
    check("R8 burst tail", int'(uopsOut), 2);
    drive(1, 5'b11111, 20'h11114, 5'b00010, 5'b00100);
    check("R2 lane0 four", int'(lane0Uops), 4);

    for (int t = 0; t < 3000; t++) begin
      logic [4:0] v, c, j;
      int nv;
      nv = $urandom_range(0, 5);
      v = 5'((1 << nv) - 1);
      if ($urandom_range(0, 9) == 0) v = 5'($urandom_range(0, 31));
      for (int s = 0; s < 5; s++) begin
        int r;
        r = $urandom_range(0, 99);
        u[s*4 +: 4] = (r < 70) ? 4'd1 : (r < 90) ? 4'($urandom_range(2, 4)) : 4'($urandom_range(5, 15));
        if (r == 99) u[s*4 +: 4] = 4'd0;
      end
      c = 5'($urandom_range(0, 31)) & 5'($urandom_range(0, 31));
      j = 5'($urandom_range(0, 31)) & 5'($urandom_range(0, 31));
      drive($urandom_range(0, 99) < 85, v, u, c, j);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule